// File: doc/BRIEF.md
# Self-Framing Serial Segment Display Driver

This block takes segment patterns over a two-wire serial link, a data line and a serial clock, with no load strobe and no select line. Each frame opens with a start bit of logic 1. When that start bit has travelled the full depth of the shift register, the block knows the frame is complete. It then copies the segment bits into a bank of holding latches and clears the shift register ready for the next frame. A host can therefore stream frames back to back, one bit per serial clock.

Each latched bit drives one segment output. The output is the latched bit XORed with a backplane waveform, so a lit segment is driven in antiphase to the backplane and a dark one in phase with it. The backplane comes from one of two sources: an internal divide-by-16 of a slow oscillator input, or an external backplane input. When the external source is selected, the internal divider is held parked. All external inputs are treated as asynchronous and synchronized into one system clock. The serial clock must stay in each phase for at least three system clock cycles.

Top module: `lcd_serial_seg_drv`

## Requirements
- R1: After reset, every segment latch is 0 and the internal backplane is low, so `seg_o` is all zeros and `bp_o` is 0 while the internal source is selected.
- R2: A frame is 36 rising serial clock edges: a 1 start bit, then 33 segment bits, then 2 bits that are ignored. The k-th bit after the start bit (k = 1..33) lands in `seg_o[k-1]`. The latches load on the 36th rising edge, and the values of the two trailing bits do not change the loaded pattern.
- R3: After a load, the shift register is cleared on the next falling serial clock edge, before the next rising edge. Frames sent with no gap between them therefore each load their own pattern.
- R4: The latches keep their contents until a complete frame is loaded. After only 35 rising edges of a frame, or after a frame that stops part-way, `seg_o` shows the previous pattern.
- R5: Each `seg_o[k]` equals latch bit k XOR `bp_o`. When the backplane toggles while the latches are stable, every segment output inverts.
- R6: With the internal source selected, `bp_o` is bit 3 of a 4-bit counter that counts rising edges of `osc_i`. It goes high after the 8th oscillator edge following reset and has a period of 16 oscillator edges.
- R7: While `bp_ext_sel_i` is 1, `bp_o` follows `bp_ext_i` and the divider is held at zero. After switching back to the internal source, `bp_o` starts low and first rises on the 8th oscillator edge.
- R8: Driving `rst_ni` low immediately clears the latches, the divider and the shift register. A partial frame sent before the reset has no effect on the first complete frame sent after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all inputs |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| ser_clk_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial segment data |
| osc_i | input | 1 | Slow oscillator feeding the internal backplane divider |
| bp_ext_sel_i | input | 1 | 1 selects the external backplane and parks the divider |
| bp_ext_i | input | 1 | External backplane waveform |
| seg_o | output | 33 | Segment drive, latched bit XOR backplane |
| bp_o | output | 1 | Backplane drive |

## Verification
The bench sends directed frames that tell apart three kinds of error: all ones and all zeros expose stuck latches, and a single set bit at the first or the last segment exposes a bit-order or off-by-one mapping fault. Trailing bits of 1 show whether the last two bits leak into the pattern. Back-to-back random frames with random trailing bits expose a missing or late clear, which would mix one frame into the next. It also compares outputs after 35 and after 36 edges, which pins the load to the correct edge. Oscillator pulse trains with both backplane sources show the divide ratio and the parking of the divider. A truncated frame followed by reset shows both that the latches hold and that reset clears the shift register.

// File: rtl/lcd_seg_pkg.sv
`timescale 1ns / 1ps
package lcd_seg_pkg;
  localparam int unsigned SEG_COUNT_DEF = 33;
  localparam int unsigned DIV_LOG2_DEF  = 4;
  localparam int unsigned SYNC_DEF      = 2;

  typedef enum logic {
    BP_INTERNAL = 1'b0,
    BP_EXTERNAL = 1'b1
  } bp_src_e;
endpackage

// File: rtl/lcd_sync_chain.sv
`timescale 1ns / 1ps
module lcd_sync_chain #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lcd_frame_rx.sv
`timescale 1ns / 1ps
module lcd_frame_rx #(
  parameter int unsigned N_SEG = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_lvl,
  input  logic             din,
  output logic             load_o,
  output logic [N_SEG-1:0] seg_data_o
);
  // start bit + data bits + first trailing bit; the 36th sample is the load edge
  localparam int unsigned SR_W = N_SEG + 2;
  localparam int unsigned TOP  = SR_W - 1;

  logic            sclk_q;
  logic            bit_rise, bit_fall;
  logic [SR_W-1:0] sr_q, sr_d;
  logic            clr_q, clr_d;

  assign bit_rise = sclk_lvl & ~sclk_q;
  assign bit_fall = ~sclk_lvl & sclk_q;
  assign load_o   = bit_rise & sr_q[TOP];

  always_comb begin
    sr_d  = sr_q;
    clr_d = clr_q;
    if (bit_fall && clr_q) begin
      sr_d  = '0;
      clr_d = 1'b0;
    end else if (load_o) begin
      clr_d = 1'b1;
    end else if (bit_rise) begin
      sr_d = {sr_q[TOP-1:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sr_q   <= '0;
      clr_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_lvl;
      sr_q   <= sr_d;
      clr_q  <= clr_d;
    end
  end

  // first data bit sits next to the start bit; reverse into segment order
  for (genvar k = 0; k < N_SEG; k++) begin : g_map
    assign seg_data_o[k] = sr_q[TOP-1-k];
  end

  a_r3_no_rise_during_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> !bit_rise);
  a_r3_cleared_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && bit_fall) |=> (sr_q == '0 && !clr_q));
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
endmodule

// File: rtl/lcd_bp_gen.sv
`timescale 1ns / 1ps
module lcd_bp_gen
  import lcd_seg_pkg::*;
#(
  parameter int unsigned DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_lvl,
  input  logic sel_lvl,
  input  logic bp_ext,
  output logic bp_o
);
  logic                osc_q;
  logic                osc_rise;
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;
  bp_src_e             src;

  assign src      = bp_src_e'(sel_lvl);
  assign osc_rise = osc_lvl & ~osc_q;

  always_comb begin
    cnt_d = cnt_q;
    if (src == BP_EXTERNAL)  cnt_d = '0;
    else if (osc_rise)       cnt_d = cnt_q + DIV_LOG2'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      osc_q <= osc_lvl;
      cnt_q <= cnt_d;
    end
  end

  assign bp_o = (src == BP_EXTERNAL) ? bp_ext : cnt_q[DIV_LOG2-1];

  a_r7_divider_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (src == BP_EXTERNAL) |=> (cnt_q == '0));
  a_r6_count_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (src == BP_INTERNAL && !osc_rise) |=> $stable(cnt_q));
endmodule

// File: rtl/lcd_serial_seg_drv.sv
`timescale 1ns / 1ps
module lcd_serial_seg_drv
  import lcd_seg_pkg::*;
#(
  parameter int unsigned N_SEG       = SEG_COUNT_DEF,
  parameter int unsigned DIV_LOG2    = DIV_LOG2_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             osc_i,
  input  logic             bp_ext_sel_i,
  input  logic             bp_ext_i,
  output logic [N_SEG-1:0] seg_o,
  output logic             bp_o
);
  localparam int unsigned N_IN = 5;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_sync;
  logic [N_IN-1:0]  in_raw, in_lvl;
  logic             load;
  logic [N_SEG-1:0] seg_data;
  logic [N_SEG-1:0] lat_q, lat_d;
  logic             bp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  assign in_raw = {bp_ext_i, bp_ext_sel_i, osc_i, ser_dat_i, ser_clk_i};

  lcd_sync_chain #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_i),
    .rst_n(rst_n_sync),
    .d    (in_raw),
    .q    (in_lvl)
  );

  lcd_frame_rx #(.N_SEG(N_SEG)) u_rx (
    .clk       (clk_i),
    .rst_n     (rst_n_sync),
    .sclk_lvl  (in_lvl[0]),
    .din       (in_lvl[1]),
    .load_o    (load),
    .seg_data_o(seg_data)
  );

  lcd_bp_gen #(.DIV_LOG2(DIV_LOG2)) u_bp (
    .clk    (clk_i),
    .rst_n  (rst_n_sync),
    .osc_lvl(in_lvl[2]),
    .sel_lvl(in_lvl[3]),
    .bp_ext (in_lvl[4]),
    .bp_o   (bp)
  );

  always_comb begin
    lat_d = lat_q;
    if (load) lat_d = seg_data;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) lat_q <= '0;
    else             lat_q <= lat_d;
  end

  assign seg_o = lat_q ^ {N_SEG{bp}};
  assign bp_o  = bp;

  a_r4_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !load |=> $stable(lat_q));
  a_r5_segments_follow_bp: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (!$stable(bp_o) && $stable(lat_q)) |-> (seg_o == ~$past(seg_o)));
endmodule

// File: tb/tb_lcd_serial_seg_drv.sv
`timescale 1ns / 1ps
module tb_lcd_serial_seg_drv;
  logic        clk = 1'b0;
  logic        rst_n, sclk, sdat, osc, sel, bpx;
  logic [32:0] seg;
  logic        bp;

  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;
  logic [32:0] exp_lat;
  int          osc_cnt;
  bit          ext_mode;

  lcd_serial_seg_drv dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .osc_i(osc), .bp_ext_sel_i(sel), .bp_ext_i(bpx), .seg_o(seg), .bp_o(bp)
  );

  always #2.5 clk = ~clk;

  function automatic logic model_bp();
    if (ext_mode) return bpx;
    return ((osc_cnt % 16) >= 8);
  endfunction

  function automatic logic [32:0] model_seg();
    return exp_lat ^ {33{model_bp()}};
  endfunction

  task automatic chk(input logic [32:0] act, input logic [32:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    sclk = 1'b0; sdat = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [32:0] s, input logic [1:0] trail, input string tag);
    ser_bit(1'b1);
    for (int k = 0; k < 33; k++) ser_bit(s[k]);
    ser_bit(trail[0]);
    chk(seg, model_seg(), "R4 unchanged after 35 edges");
    ser_bit(trail[1]);
    exp_lat = s;
    chk(seg, model_seg(), tag);
  endtask

  task automatic osc_pulse();
    osc = 1'b1; repeat (3) @(negedge clk);
    osc = 1'b0; repeat (3) @(negedge clk);
    if (!ext_mode) osc_cnt++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_lat = '0; osc_cnt = 0;
    sclk = 1'b0; sdat = 1'b0; osc = 1'b0;
    chk(seg, 33'h0, "R8 segments cleared at reset");
    chk({32'h0, bp}, 33'h0, "R8 backplane low at reset");
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [32:0] r;
    int unsigned seed_init;
    seed_init = $urandom(32'd48151);
    rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; osc = 1'b0; sel = 1'b0; bpx = 1'b0;
    exp_lat = '0; osc_cnt = 0; ext_mode = 1'b0;
    repeat (5) @(negedge clk);
    chk(seg, 33'h0, "R1 reset segments");
    chk({32'h0, bp}, 33'h0, "R1 reset backplane");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // directed frames
    send_frame({33{1'b1}}, 2'b00, "R2 all ones");
    send_frame(33'h1, 2'b11, "R2 first segment, trailing ones ignored");
    send_frame(33'h1 << 32, 2'b11, "R2 last segment");
    send_frame(33'h0_AAAA_5555, 2'b01, "R2 mixed pattern");
    send_frame(33'h0, 2'b10, "R2 all zeros");

    // back-to-back random frames
    for (int i = 0; i < 8; i++) begin
      r = {$urandom, $urandom};
      send_frame(r, 2'($urandom), "R3 back-to-back random frame");
    end

    // internal backplane divider
    for (int i = 0; i < 20; i++) begin
      osc_pulse();
      chk({32'h0, bp}, {32'h0, model_bp()}, "R6 backplane divide by 16");
      if (i == 7 || i == 16) chk(seg, model_seg(), "R5 segments invert with backplane");
    end

    // external backplane
    sel = 1'b1; bpx = 1'b1; ext_mode = 1'b1;
    repeat (4) @(negedge clk);
    chk({32'h0, bp}, 33'h1, "R7 external backplane high");
    chk(seg, ~exp_lat, "R5 segments with external backplane");
    for (int i = 0; i < 3; i++) osc_pulse();
    bpx = 1'b0;
    repeat (4) @(negedge clk);
    chk({32'h0, bp}, 33'h0, "R7 external backplane low");
    sel = 1'b0; ext_mode = 1'b0; osc_cnt = 0;
    repeat (4) @(negedge clk);
    chk({32'h0, bp}, 33'h0, "R7 divider parked at zero");
    for (int i = 0; i < 8; i++) osc_pulse();
    chk({32'h0, bp}, 33'h1, "R7 first rise on 8th edge");
    send_frame(33'h1_2345_6789, 2'b00, "R2 load with backplane high");

    // truncated frame then reset
    ser_bit(1'b1);
    for (int k = 0; k < 20; k++) ser_bit(1'($urandom));
    repeat (10) @(negedge clk);
    chk(seg, model_seg(), "R4 partial frame ignored");
    do_reset();
    r = {$urandom, $urandom};
    send_frame(r, 2'b00, "R8 clean frame after reset");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule